// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records a stream of trace words into an on-chip circular RAM. While capture is enabled, each valid word is stored at the write pointer and the pointer steps forward, wrapping at the end of the RAM. A debug host reaches the buffer through a small register port: an address, write data, a write strobe, a read strobe and read data. Through this port the host sizes the buffer, arms a trigger and then unloads the RAM contents.

Reads of the RAM-data register are destructive. Each one returns the entry at the read pointer and moves that pointer forward by one. The host can also write the read pointer directly. A sticky wrap flag in the status register tells the host where the oldest entry sits. When the flag is set, the oldest entry is at the write pointer. When it is clear, valid data starts at entry zero. After a trigger, capture runs for a programmed number of further words and then stops.

Top module: `trace_ring_buf`

## Requirements
- R1: After reset, the read pointer, the write pointer, the status register (address 3) and the control register (address 8) all read zero.
- R2: Address 0 reads the ID_CODE parameter, address 1 reads DEPTH and address 2 reads WIDTH. Writes to these addresses have no effect, and any address above 8 reads zero.
- R3: While control bit 0 is set, each cycle with trc_valid high stores trc_data at the write pointer (address 6). The pointer then advances by one modulo DEPTH. While control bit 0 is clear, nothing is stored and the write pointer holds its value.
- R4: Status bit 1 is set when the write pointer wraps from DEPTH-1 to 0. It stays set until reset.
- R5: A read strobe at address 4 returns, zero-extended and in the same cycle, the RAM entry at the read pointer. The read pointer (address 5) then advances by one modulo DEPTH.
- R6: A write to address 5 loads the read pointer with the low log2(DEPTH) bits of the write data.
- R7: A trigger pulse while capture is enabled sets status bit 0. A word that arrives in the trigger cycle is still captured. After that, exactly as many further words as the trigger counter (address 7, read/write) holds are captured. Capture then stops and status bit 2 is set.
- R8: A trigger pulse while control bit 0 is clear is ignored, and status bit 0 stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | WIDTH | Trace word |
| trig | input | 1 | Trigger event |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe, which advances the read pointer at address 4 |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
The assertions assume that one register access is presented at a time. They also assume that a read strobe is one cycle long, so that each pulse at address 4 means exactly one unload step. The bench drives each strobe for a single cycle from the falling edge. It samples read data before the rising edge that applies the access, and it never asserts the read and write strobes together. A bench model array, indexed by an expected write pointer, predicts every unloaded word across the wrap.

// File: rtl/trace_ring_buf.sv
module trace_ring_buf #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 24,
  parameter logic [31:0] ID_CODE = 32'h7452_0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trc_valid,
  input  logic [WIDTH-1:0] trc_data,
  input  logic             trig,
  input  logic [6:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             reg_we,
  input  logic             reg_re,
  output logic [31:0]      reg_rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic wrapped, trigd, enable;
  logic [31:0] tcount, remain;

  wire stopped  = trigd && (remain == 32'd0);
  wire cap      = enable && trc_valid && !stopped;
  wire hit      = enable && trig && !trigd;
  wire wr_rptr  = reg_we && (reg_addr == 7'd5);
  wire wr_tcnt  = reg_we && (reg_addr == 7'd7);
  wire wr_ctrl  = reg_we && (reg_addr == 7'd8);
  wire rd_data  = reg_re && (reg_addr == 7'd4);

  always_ff @(posedge clk)
    if (cap) mem[wptr] <= trc_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      wrapped <= 1'b0;
      trigd   <= 1'b0;
      enable  <= 1'b0;
      tcount  <= '0;
      remain  <= '0;
    end else begin
      if (cap) begin
        wptr <= wptr + 1'b1;
        if (wptr == AW'(DEPTH - 1)) wrapped <= 1'b1;
      end
      if (wr_rptr)      rptr <= reg_wdata[AW-1:0];
      else if (rd_data) rptr <= rptr + 1'b1;
      if (wr_tcnt) tcount <= reg_wdata;
      if (wr_ctrl) enable <= reg_wdata[0];
      if (hit) begin
        trigd  <= 1'b1;
        remain <= tcount;
      end else if (trigd && cap) begin
        remain <= remain - 32'd1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      7'd0:    reg_rdata = ID_CODE;
      7'd1:    reg_rdata = 32'(DEPTH);
      7'd2:    reg_rdata = 32'(WIDTH);
      7'd3:    reg_rdata = {29'd0, stopped, wrapped, trigd};
      7'd4:    reg_rdata = 32'(mem[rptr]);
      7'd5:    reg_rdata = 32'(rptr);
      7'd6:    reg_rdata = 32'(wptr);
      7'd7:    reg_rdata = tcount;
      7'd8:    reg_rdata = {31'd0, enable};
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

module trace_ring_buf_chk #(parameter int AW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic [6:0]    reg_addr,
  input logic [31:0]   reg_rdata,
  input logic          reg_re,
  input logic          reg_we,
  input logic [AW-1:0] wptr,
  input logic [AW-1:0] rptr,
  input logic          wrapped,
  input logic          stopped,
  input logic          cap
);
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > 7'd8) |-> (reg_rdata == 32'd0));
  a_r3_capture_step: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (wptr == AW'($past(wptr) + 1'b1)));
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(wptr));
  a_r4_wrap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped |=> wrapped);
  a_r5_read_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && !reg_we && reg_addr == 7'd4) |=> (rptr == AW'($past(rptr) + 1'b1)));
  a_r7_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> (stopped && !cap));
endmodule

bind trace_ring_buf trace_ring_buf_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .reg_re(reg_re), .reg_we(reg_we), .wptr(wptr), .rptr(rptr),
  .wrapped(wrapped), .stopped(stopped), .cap(cap)
);

// File: tb/sim_trace_ring_buf.sv
`timescale 1ns/1ps
module sim_trace_ring_buf;
  localparam int DEPTH = 16;
  localparam int WIDTH = 24;
  localparam logic [31:0] ID = 32'h7452_0001;

  logic clk = 0, rst_n = 0, trc_valid = 0, trig = 0, reg_we = 0, reg_re = 0;
  logic [WIDTH-1:0] trc_data = '0;
  logic [6:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int checks = 0, failures = 0;
  logic [WIDTH-1:0] model [DEPTH];
  int exp_wp = 0;

  always #5 clk = ~clk;

  trace_ring_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ID_CODE(ID)) u0 (
    .clk(clk), .rst_n(rst_n), .trc_valid(trc_valid), .trc_data(trc_data), .trig(trig),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_re = 1; #1 d = reg_rdata;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic push(logic [WIDTH-1:0] w, bit stored);
    @(negedge clk); trc_valid = 1; trc_data = w;
    @(negedge clk); trc_valid = 0;
    if (stored) begin model[exp_wp] = w; exp_wp = (exp_wp + 1) % DEPTH; end
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3, v); chk("R1 status", v, 0);
    rd(5, v); chk("R1 rptr", v, 0);
    rd(6, v); chk("R1 wptr", v, 0);
    rd(8, v); chk("R1 ctrl", v, 0);
  endtask

  task automatic t_consts();
    logic [31:0] v;
    rd(0, v); chk("R2 id", v, ID);
    rd(1, v); chk("R2 depth", v, DEPTH);
    rd(2, v); chk("R2 width", v, WIDTH);
    wr(1, 32'h55); rd(1, v); chk("R2 depth write ignored", v, DEPTH);
    rd(9, v); chk("R2 unmapped", v, 0);
    rd(7'h7f, v); chk("R2 unmapped top", v, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    push(24'hdead01, 0);
    rd(6, v); chk("R3 disabled no capture", v, 0);
  endtask

  task automatic t_fill_read();
    logic [31:0] v;
    wr(8, 1);
    for (int i = 0; i < 5; i++) push(24'h000100 + 24'(i), 1);
    rd(6, v); chk("R3 wptr after 5", v, 5);
    rd(3, v); chk("R4 no wrap yet", v, 0);
    wr(5, 0);
    for (int i = 0; i < 5; i++) begin
      rd(4, v); chk("R5 data read", v, 32'(model[i]));
    end
    rd(5, v); chk("R5 rptr advanced", v, 5);
    wr(5, 2); rd(4, v); chk("R6 rptr load", v, 32'(model[2]));
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    for (int i = 0; i < 14; i++) push(24'h00a000 + 24'(i * 7), 1);
    rd(6, v); chk("R3 wptr modulo", v, 3);
    rd(3, v); chk("R4 wrap flag", v, 2);
    wr(5, 3);
    for (int i = 0; i < DEPTH; i++) begin
      rd(4, v); chk("R5 oldest-first unload", v, 32'(model[(3 + i) % DEPTH]));
    end
    rd(5, v); chk("R5 rptr wraps", v, 3);
  endtask

  task automatic t_trigger();
    logic [31:0] v;
    wr(8, 0); pulse_trig();
    rd(3, v); chk("R8 trigger ignored when disabled", v, 2);
    wr(7, 3); rd(7, v); chk("R7 trigger counter rw", v, 3);
    wr(8, 1); pulse_trig();
    rd(3, v); chk("R7 trigger seen", v, 3);
    for (int i = 0; i < 5; i++) push(24'h00c000 + 24'(i), i < 3);
    rd(6, v); chk("R7 only counted words stored", v, 6);
    rd(3, v); chk("R7 stopped", v, 7);
    wr(5, 3);
    for (int i = 0; i < 3; i++) begin
      rd(4, v); chk("R7 post-trigger data", v, 32'(model[3 + i]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_consts(); t_disabled(); t_fill_read(); t_wrap(); t_trigger();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule